// File: doc/BRIEF.md
# Boot Mode Strap Latch with Shared Interrupt and GPIO Pins

This block sits behind a group of shared external pins on a two-core processor. While the active-low reset is held low, it keeps sampling four strap pins per core. When reset is released, the last sampled levels become that core's 4-bit initial operating mode, so there are 16 possible start-up modes per core. Core 0's first two strap pins carry a second job after boot.

After reset those two pins become active-low external interrupt request lines. Each passes through a two-flop synchronizer on the core clock, and both cores share them. Each core has its own enable (mask) bit and its own trigger-style bit for each line. In level style, a request is raised while the synchronized pin is low. In edge style, a falling edge sets a per-core pending flag that stays set until that core acknowledges it.

Either core can reassign either pin as a general-purpose input, a driven output or a disconnected pin, and can later return it to interrupt use. When a core is in stop standby and the first pin is low and still in interrupt use, a wake output is raised combinationally, without waiting for a clock edge.

Top module: `bootstrap_irq_pins`

## Requirements
- R1: While rst_n is low, pad_oe and pad_out are 0, every interrupt request output is 0, both pins are in interrupt use, and gpio_rd reads all ones.
- R2: While rst_n is low, boot_mode_c0 follows {c0_strap_hi, pad_in} and boot_mode_c1 follows c1_strap. Bit 0 is strap A, bit 1 is B, bit 2 is C and bit 3 is D, with core 0's A and B being pad_in[0] and pad_in[1]. Each value is taken at every rising edge of clk that sees rst_n low.
- R3: After rst_n goes high, both boot modes keep the value from the last clock edge of reset, whatever the strap pins do.
- R4: For a pin in interrupt use with level style (edge bit 0) and enable bit 1, the core's request equals the inverted pin level delayed by two rising clock edges. It drops two edges after the pin returns high.
- R5: For a pin in edge style (edge bit 1) with enable bit 1, a high-to-low pin transition raises the core's request on the third rising edge after the pin change. The request stays up after the pin returns high, until that core acknowledges it.
- R6: An acknowledge pulse clears the core's pending flag at the next edge. If a new falling edge is detected at the same edge as the acknowledge, the flag stays set.
- R7: Enable and trigger-style bits are separate per core and per pin. A pin edge seen while one core's enable bit is 0 raises no request for that core and has no effect on the other core.
- R8: Configuration code per pin: 00 interrupt use, 01 GPIO input, 10 GPIO output, 11 disconnected. A write (we, sel = pin index, cfg code, out value) takes effect at the next edge. In output mode, pad_oe is 1, pad_out is the written value and gpio_rd returns that value. In input mode, gpio_rd returns the synchronized pin after two edges. Disconnected and interrupt-use pins read as 1, and pad_out is 0 outside output mode.
- R9: A pin in any GPIO code (01, 10 or 11) gives no interrupt request to either core. Its pending flags are cleared, so returning it to code 00 does not bring back an older edge.
- R10: If both cores strobe a configuration write in the same cycle, only core 0's write is applied.
- R11: wake is 1 exactly when stop_mode is 1, pad_in[0] is 0 and pin 0 is in interrupt use. It responds with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; its release latches the boot modes |
| pad_in | input | 2 | Levels of the two shared pins (core 0 straps A, B / interrupt lines) |
| c0_strap_hi | input | 2 | Core 0 straps C (bit 0) and D (bit 1) |
| c1_strap | input | 4 | Core 1 straps A..D |
| boot_mode_c0 | output | 4 | Latched initial mode of core 0 |
| boot_mode_c1 | output | 4 | Latched initial mode of core 1 |
| c0_irq_en | input | 2 | Core 0 per-pin enable (1 = unmasked) |
| c0_irq_edge | input | 2 | Core 0 per-pin trigger style (1 = falling edge) |
| c0_irq_ack | input | 2 | Core 0 per-pin acknowledge pulse |
| c0_irq_req | output | 2 | Core 0 per-pin interrupt request |
| c1_irq_en | input | 2 | Core 1 per-pin enable |
| c1_irq_edge | input | 2 | Core 1 per-pin trigger style |
| c1_irq_ack | input | 2 | Core 1 per-pin acknowledge pulse |
| c1_irq_req | output | 2 | Core 1 per-pin interrupt request |
| c0_gpio_we | input | 1 | Core 0 configuration write strobe |
| c0_gpio_sel | input | 1 | Core 0 target pin index |
| c0_gpio_cfg | input | 2 | Core 0 configuration code |
| c0_gpio_out | input | 1 | Core 0 output value |
| c1_gpio_we | input | 1 | Core 1 configuration write strobe |
| c1_gpio_sel | input | 1 | Core 1 target pin index |
| c1_gpio_cfg | input | 2 | Core 1 configuration code |
| c1_gpio_out | input | 1 | Core 1 output value |
| pad_out | output | 2 | Pin drive value |
| pad_oe | output | 2 | Pin drive enable |
| gpio_rd | output | 2 | GPIO read value per pin |
| stop_mode | input | 1 | High while a core is in stop standby |
| wake | output | 1 | Stop-standby exit request |

## Verification
An acknowledge from a core and a fresh falling edge on the same line can land on the same clock edge, and the new edge has to win. The bench sets up an existing pending request and raises the line. It then lowers the line again and times the acknowledge pulse so that it meets the edge at which the synchronized fall is registered. The request must still be up one cycle later, and a second lone acknowledge must then clear it. Two configuration writes from both cores in one cycle are provoked the same way and judged by which core's code appears on pad_oe and pad_out.

// File: rtl/bmi_pkg.sv
// Shared types for the boot strap / interrupt pin block.
// Assumes a two-bit configuration code per shared pin.
package bmi_pkg;

    typedef enum logic [1:0] {
        PIN_IRQ = 2'b00,
        PIN_GPI = 2'b01,
        PIN_GPO = 2'b10,
        PIN_OFF = 2'b11
    } pin_cfg_e;

    localparam int NUM_CORES = 2;

endpackage

// File: rtl/bmi_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes pins idle high (pull-up), so every stage resets to RST_VAL.
module bmi_sync #(
    parameter int             W       = 2,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the raw level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= RST_VAL;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/bmi_strap_latch.sv
// Boot-mode strap capture: follows the strap pins while reset is low and
// freezes on release. Assumes the straps are static around reset release.
module bmi_strap_latch #(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] strap,
    output logic [MODE_W-1:0] mode
);

    // Track straps during reset; hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= strap;
        end
    end

endmodule

// File: rtl/bmi_gpio_cfg.sv
// Per-pin configuration and output registers written by two cores.
// Assumes at most one write per cycle is applied; core 0 has priority.
module bmi_gpio_cfg
    import bmi_pkg::*;
#(
    parameter int NUM_PINS = 2,
    parameter int SEL_W    = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            we,
    input  logic [1:0][SEL_W-1:0] sel,
    input  logic [1:0][1:0]       wcfg,
    input  logic [1:0]            wout,
    output pin_cfg_e              cfg_q [NUM_PINS],
    output logic [NUM_PINS-1:0]   out_q
);

    logic             win_we;
    logic [SEL_W-1:0] win_sel;
    logic [1:0]       win_cfg;
    logic             win_out;

    // Pick the applied write: core 0 first, else core 1.
    always_comb begin
        win_we  = we[0] | we[1];
        win_sel = we[0] ? sel[0]  : sel[1];
        win_cfg = we[0] ? wcfg[0] : wcfg[1];
        win_out = we[0] ? wout[0] : wout[1];
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // Hold the configuration code and output bit of one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[p] <= PIN_IRQ;
                out_q[p] <= 1'b0;
            end else if (win_we && (win_sel == SEL_W'(p))) begin
                cfg_q[p] <= pin_cfg_e'(win_cfg);
                out_q[p] <= win_out;
            end
        end
    end

endmodule

// File: rtl/bmi_irq_chan.sv
// One interrupt channel: one pin as seen by one core.
// Assumes pin_s is synchronized and fall is a one-cycle falling-edge flag.
module bmi_irq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_use,
    input  logic pin_s,
    input  logic fall,
    input  logic en,
    input  logic edge_sel,
    input  logic ack,
    output logic req
);

    logic pend;

    // Pending flag: a new edge beats acknowledge; GPIO use clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (!irq_use) begin
            pend <= 1'b0;
        end else if (en && edge_sel && fall) begin
            pend <= 1'b1;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end

    // Request from either the latched edge or the live low level.
    always_comb begin
        req = irq_use & en & (edge_sel ? pend : ~pin_s);
    end

endmodule

// File: rtl/bootstrap_irq_pins.sv
// Top: boot-mode strap latch, shared interrupt lines, GPIO reuse and
// stop-standby wake for two pins shared by two cores.
// Assumes pins are pulled up externally and straps are stable at reset release.
module bootstrap_irq_pins
    import bmi_pkg::*;
#(
    parameter int  NUM_PINS    = 2,
    parameter int  MODE_W      = 4,
    parameter int  SYNC_STAGES = 2,
    localparam int SEL_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int HI_W        = MODE_W - NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [HI_W-1:0]     c0_strap_hi,
    input  logic [MODE_W-1:0]   c1_strap,
    output logic [MODE_W-1:0]   boot_mode_c0,
    output logic [MODE_W-1:0]   boot_mode_c1,
    input  logic [NUM_PINS-1:0] c0_irq_en,
    input  logic [NUM_PINS-1:0] c0_irq_edge,
    input  logic [NUM_PINS-1:0] c0_irq_ack,
    output logic [NUM_PINS-1:0] c0_irq_req,
    input  logic [NUM_PINS-1:0] c1_irq_en,
    input  logic [NUM_PINS-1:0] c1_irq_edge,
    input  logic [NUM_PINS-1:0] c1_irq_ack,
    output logic [NUM_PINS-1:0] c1_irq_req,
    input  logic                c0_gpio_we,
    input  logic [SEL_W-1:0]    c0_gpio_sel,
    input  logic [1:0]          c0_gpio_cfg,
    input  logic                c0_gpio_out,
    input  logic                c1_gpio_we,
    input  logic [SEL_W-1:0]    c1_gpio_sel,
    input  logic [1:0]          c1_gpio_cfg,
    input  logic                c1_gpio_out,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] gpio_rd,
    input  logic                stop_mode,
    output logic                wake
);

    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] pin_prev;
    logic [NUM_PINS-1:0] pin_fall;
    logic [NUM_PINS-1:0] out_q;
    pin_cfg_e            cfg_q [NUM_PINS];

    // Boot strap capture for each core.
    bmi_strap_latch #(.MODE_W(MODE_W)) u_strap0 (
        .clk   (clk),
        .rst_n (rst_n),
        .strap ({c0_strap_hi, pad_in}),
        .mode  (boot_mode_c0)
    );

    bmi_strap_latch #(.MODE_W(MODE_W)) u_strap1 (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (c1_strap),
        .mode  (boot_mode_c1)
    );

    // Pin synchronizer on the core clock.
    bmi_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_s)
    );

    // Previous synchronized level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev <= '1;
        end else begin
            pin_prev <= pin_s;
        end
    end

    assign pin_fall = pin_prev & ~pin_s;

    // Configuration registers shared by both cores.
    bmi_gpio_cfg #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ({c1_gpio_we, c0_gpio_we}),
        .sel   ({c1_gpio_sel, c0_gpio_sel}),
        .wcfg  ({c1_gpio_cfg, c0_gpio_cfg}),
        .wout  ({c1_gpio_out, c0_gpio_out}),
        .cfg_q (cfg_q),
        .out_q (out_q)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic irq_use;

        assign irq_use = (cfg_q[p] == PIN_IRQ);

        bmi_irq_chan u_ch0 (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_use  (irq_use),
            .pin_s    (pin_s[p]),
            .fall     (pin_fall[p]),
            .en       (c0_irq_en[p]),
            .edge_sel (c0_irq_edge[p]),
            .ack      (c0_irq_ack[p]),
            .req      (c0_irq_req[p])
        );

        bmi_irq_chan u_ch1 (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_use  (irq_use),
            .pin_s    (pin_s[p]),
            .fall     (pin_fall[p]),
            .en       (c1_irq_en[p]),
            .edge_sel (c1_irq_edge[p]),
            .ack      (c1_irq_ack[p]),
            .req      (c1_irq_req[p])
        );

        // Pad drive and read-back value per configuration code.
        always_comb begin
            pad_oe[p]  = 1'b0;
            pad_out[p] = 1'b0;
            gpio_rd[p] = 1'b1;
            case (cfg_q[p])
                PIN_GPI: gpio_rd[p] = pin_s[p];
                PIN_GPO: begin
                    pad_oe[p]  = 1'b1;
                    pad_out[p] = out_q[p];
                    gpio_rd[p] = out_q[p];
                end
                default: gpio_rd[p] = 1'b1;
            endcase
        end
    end

    // Asynchronous stop-standby exit on a low first pin.
    always_comb begin
        wake = stop_mode & ~pad_in[0] & (cfg_q[0] == PIN_IRQ);
    end

endmodule

// File: rtl/bmi_chk.sv
// Property checker for bootstrap_irq_pins; attached by bind below.
module bmi_chk #(
    parameter int NUM_PINS = 2,
    parameter int MODE_W   = 4,
    parameter int SEL_W    = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [MODE_W-1:0]   boot_mode_c0,
    input logic [MODE_W-1:0]   boot_mode_c1,
    input logic [NUM_PINS-1:0] c0_irq_en,
    input logic [NUM_PINS-1:0] c0_irq_edge,
    input logic [NUM_PINS-1:0] c0_irq_ack,
    input logic [NUM_PINS-1:0] c0_irq_req,
    input logic [NUM_PINS-1:0] c1_irq_req,
    input logic                c0_gpio_we,
    input logic [SEL_W-1:0]    c0_gpio_sel,
    input logic [1:0]          c0_gpio_cfg,
    input logic                c1_gpio_we,
    input logic [SEL_W-1:0]    c1_gpio_sel,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic                stop_mode,
    input logic                wake
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && c0_irq_req == '0 && c1_irq_req == '0));

    // R3
    boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(boot_mode_c0) && $stable(boot_mode_c1)));

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_irq_req[1] && c0_irq_edge[1] && c0_irq_en[1] && !c0_irq_ack[1]
         && !c0_gpio_we && !c1_gpio_we)
        |=> (c0_irq_req[1] || !c0_irq_edge[1] || !c0_irq_en[1]));

    // R8
    gpo_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && c0_gpio_we && c0_gpio_sel == '0 && c0_gpio_cfg == 2'b10)
        |-> pad_oe[0]);

    // R9
    gpio_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[0] |-> (!c0_irq_req[0] && !c1_irq_req[0]));

    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && c0_gpio_we && c1_gpio_we && c0_gpio_sel == c1_gpio_sel)
        |-> (pad_oe[$past(c0_gpio_sel)] == ($past(c0_gpio_cfg) == 2'b10)));

    // R11
    wake_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (stop_mode && !pad_in[0]));

endmodule

bind bootstrap_irq_pins bmi_chk #(
    .NUM_PINS (NUM_PINS),
    .MODE_W   (MODE_W),
    .SEL_W    (SEL_W)
) chk_i (.*);

// File: tb/bootstrap_irq_pins_tb_top.sv
`timescale 1ns/1ps
module bootstrap_irq_pins_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pad_in = 2'b11;
    logic [1:0] c0_strap_hi = 2'b00;
    logic [3:0] c1_strap = 4'h0;
    logic [3:0] boot_mode_c0, boot_mode_c1;
    logic [1:0] c0_irq_en = '0, c0_irq_edge = '0, c0_irq_ack = '0, c0_irq_req;
    logic [1:0] c1_irq_en = '0, c1_irq_edge = '0, c1_irq_ack = '0, c1_irq_req;
    logic       c0_gpio_we = 0, c0_gpio_sel = 0, c0_gpio_out = 0;
    logic [1:0] c0_gpio_cfg = 2'b00;
    logic       c1_gpio_we = 0, c1_gpio_sel = 0, c1_gpio_out = 0;
    logic [1:0] c1_gpio_cfg = 2'b00;
    logic [1:0] pad_out, pad_oe, gpio_rd;
    logic       stop_mode = 0, wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bootstrap_irq_pins dut_i (.*);

    // Vector: [7] pin, [6:5] code, [4] out value, [3] pad level,
    //         [2] expected pad_oe, [1] expected pad_out, [0] expected gpio_rd
    localparam logic [7:0] GPIO_VEC [9] = '{
        8'b0_01_0_0_000,
        8'b0_01_0_1_001,
        8'b0_10_1_0_111,
        8'b0_10_0_1_100,
        8'b0_11_1_0_001,
        8'b1_01_0_0_000,
        8'b1_10_1_1_111,
        8'b1_00_0_0_001,
        8'b0_00_0_1_001
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic c1_write(input logic sel, input logic [1:0] code, input logic val);
        c1_gpio_we = 1; c1_gpio_sel = sel; c1_gpio_cfg = code; c1_gpio_out = val;
        tick();
        c1_gpio_we = 0;
    endtask

    task automatic c0_write(input logic sel, input logic [1:0] code, input logic val);
        c0_gpio_we = 1; c0_gpio_sel = sel; c0_gpio_cfg = code; c0_gpio_out = val;
        tick();
        c0_gpio_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Reset with straps: core0 A=0 B=1 C=1 D=1, core1 = 0101
        pad_in = 2'b10; c0_strap_hi = 2'b11; c1_strap = 4'b0101;
        @(negedge clk);
        repeat (3) tick();
        chk("R1 pad_oe in reset", pad_oe, 0);
        chk("R1 pad_out in reset", pad_out, 0);
        chk("R1 req in reset", {c0_irq_req, c1_irq_req}, 0);
        chk("R1 gpio_rd in reset", gpio_rd, 2'b11);
        chk("R2 core1 mode tracks", boot_mode_c1, 4'b0101);
        c1_strap = 4'b0110;
        tick();
        chk("R2 core1 mode follows change", boot_mode_c1, 4'b0110);
        rst_n = 1;
        tick();
        chk("R2 core0 mode latched", boot_mode_c0, 4'b1110);
        pad_in = 2'b11; c0_strap_hi = 2'b00; c1_strap = 4'b1001;
        repeat (3) tick();
        chk("R3 core0 mode held", boot_mode_c0, 4'b1110);
        chk("R3 core1 mode held", boot_mode_c1, 4'b0110);

        // GPIO configuration vectors written by core 1 (R8)
        for (int i = 0; i < 9; i++) begin
            logic [7:0] v;
            v = GPIO_VEC[i];
            c1_write(v[7], v[6:5], v[4]);
            pad_in = 2'b11;
            pad_in[v[7]] = v[3];
            repeat (3) tick();
            chk($sformatf("R8 vec%0d pad_oe", i), pad_oe[v[7]], v[2]);
            chk($sformatf("R8 vec%0d pad_out", i), pad_out[v[7]], v[1]);
            chk($sformatf("R8 vec%0d gpio_rd", i), gpio_rd[v[7]], v[0]);
        end
        pad_in = 2'b11;
        repeat (3) tick();

        // Level style on pin 0, core 0 only (R4, R7)
        c0_irq_en = 2'b01; c0_irq_edge = 2'b00;
        pad_in[0] = 0;
        tick();
        chk("R4 level after one edge", c0_irq_req[0], 0);
        tick();
        chk("R4 level after two edges", c0_irq_req[0], 1);
        chk("R7 core1 masked level", c1_irq_req[0], 0);
        pad_in[0] = 1;
        tick();
        chk("R4 level held one edge", c0_irq_req[0], 1);
        tick();
        chk("R4 level released", c0_irq_req[0], 0);

        // Edge style on pin 1 (R5, R6, R7)
        c0_irq_en = 2'b10; c0_irq_edge = 2'b10;
        c1_irq_en = 2'b00; c1_irq_edge = 2'b10;
        pad_in[1] = 0;
        tick(); tick();
        chk("R5 edge not yet pending", c0_irq_req[1], 0);
        tick();
        chk("R5 edge pending", c0_irq_req[1], 1);
        chk("R7 core1 masked edge", c1_irq_req[1], 0);
        pad_in[1] = 1;
        repeat (4) tick();
        chk("R5 pending kept after rise", c0_irq_req[1], 1);
        pad_in[1] = 0;
        tick(); tick();
        c0_irq_ack[1] = 1;
        tick();
        c0_irq_ack[1] = 0;
        chk("R6 edge beats ack", c0_irq_req[1], 1);
        c0_irq_ack[1] = 1;
        tick();
        c0_irq_ack[1] = 0;
        chk("R6 ack clears", c0_irq_req[1], 0);
        c1_irq_en = 2'b10;
        pad_in[1] = 1;
        repeat (3) tick();
        pad_in[1] = 0;
        repeat (3) tick();
        chk("R7 core1 pending when enabled", c1_irq_req[1], 1);
        chk("R7 core0 pending again", c0_irq_req[1], 1);

        // GPIO use clears pending (R9)
        c1_write(1'b1, 2'b01, 1'b0);
        chk("R9 req gone in GPIO", {c0_irq_req[1], c1_irq_req[1]}, 0);
        c1_write(1'b1, 2'b00, 1'b0);
        chk("R9 pending not restored", {c0_irq_req[1], c1_irq_req[1]}, 0);

        // Wake and GPIO gating on pin 0 (R11, R9)
        c0_irq_en = 2'b01; c0_irq_edge = 2'b00;
        stop_mode = 1;
        pad_in[0] = 0;
        #1;
        chk("R11 wake without clock", wake, 1);
        tick(); tick();
        chk("R4 level request with stop", c0_irq_req[0], 1);
        c0_write(1'b0, 2'b01, 1'b0);
        chk("R11 wake blocked in GPIO", wake, 0);
        chk("R9 level req blocked in GPIO", c0_irq_req[0], 0);
        stop_mode = 0;

        // Simultaneous writes (R10)
        c0_gpio_we = 1; c0_gpio_sel = 0; c0_gpio_cfg = 2'b10; c0_gpio_out = 1;
        c1_gpio_we = 1; c1_gpio_sel = 0; c1_gpio_cfg = 2'b11; c1_gpio_out = 0;
        tick();
        c0_gpio_we = 0; c1_gpio_we = 0;
        chk("R10 core0 write wins oe", pad_oe[0], 1);
        chk("R10 core0 write wins out", pad_out[0], 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule